// File: doc/BRIEF.md
# Smart-card character transmitter

This block serialises bytes onto a single open line in the asynchronous character format that contact smart cards use. A byte is offered on `in_data` with `in_valid` and is taken on any rising edge where `in_ready` is high. It waits in a four-entry queue until the frame sequencer is free. The sequencer then drives a low start bit and the eight data bits, least significant first. An even parity bit that the block computes itself comes next, and then a guard period of two bit times with the line high. One character therefore takes twelve elementary time units (ETU).

Bit timing comes from a tick divider. One tick lasts `max(divisor,1)` clock cycles, and every bit on the line lasts exactly five ticks. System software chooses `divisor` as the clock rate divided by five times the desired baud rate. The divider is held cleared while no character is in flight, so every character starts on a clean tick boundary. `idle` tells a driver that nothing is queued and the last character, guard period included, has fully left the line. The `enable` input stops new characters from starting but never cuts one short.

Top module: `sc_char_tx`

## Requirements
- R1: After a synchronous active-high reset, `line_out` is 1, `idle` is 1 and `in_ready` is 1.
- R2: One ETU lasts 5 × max(`divisor`,1) clock cycles, so a `divisor` of 0 times exactly like a `divisor` of 1. The line does not change between ticks.
- R3: A character starts with the line at 0 for one ETU. Data bits 0 through 7 follow, in that order, one ETU each.
- R4: The tenth ETU of a character carries a parity bit equal to the XOR of the 8 data bits, so data plus parity hold an even number of ones.
- R5: After the parity bit the line is 1 for two ETU, so one character lasts 12 ETU.
- R6: While no character is in flight, `line_out` is 1.
- R7: The queue holds up to 4 bytes. `in_ready` is 0 while it holds 4, and a byte offered then is dropped. Accepted bytes go out in the order they were accepted.
- R8: When another byte is waiting and `enable` is 1, its start bit begins on the cycle right after the previous guard period ends, with no idle cycles between.
- R9: `idle` is 1 only when the queue is empty and no character is in flight.
- R10: While `enable` is 0, no new character starts and the line stays 1. A character already in flight still completes.
- R11: When the block is idle and `enable` is 1, a byte accepted on rising edge W drives the line to 0 from rising edge W+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new characters to start |
| divisor | input | 16 | Clock cycles per tick (0 treated as 1) |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Queue can accept a byte |
| line_out | output | 1 | Serial line, high when idle |
| idle | output | 1 | Queue empty and no character in flight |

## Verification
Some properties are checked on every cycle. An idle block has its line high. The queue never exceeds four entries and is never popped while empty. A character is only launched while `enable` is high. The line holds its level between ticks, and a falling edge never coincides with the idle flag. Other behaviour needs the bench's scenarios: a monitor checks every cycle of every bit against a frame model, so bit order, parity value, the exact ETU length for each divisor and the two-ETU guard are all exercised. Directed cases cover the zero gap between queued characters, the one-cycle launch latency, a dropped byte when the queue is full, and a character finishing after `enable` falls in its middle.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    // Ticks making up one elementary time unit on the line.
    localparam int ETU_TICKS = 5;
    // Bit slots per character: start, 8 data, parity, 2 guard.
    localparam int FRAME_LEN = 12;

    typedef logic [2:0]           tick_idx_t;
    typedef logic [3:0]           slot_idx_t;
    typedef logic [FRAME_LEN-1:0] frame_t;

    typedef struct packed {
        logic      busy;
        tick_idx_t sub;
        slot_idx_t slot;
        frame_t    frame;
    } seq_state_t;

    localparam tick_idx_t LAST_SUB  = tick_idx_t'(ETU_TICKS - 1);
    localparam slot_idx_t LAST_SLOT = slot_idx_t'(FRAME_LEN - 1);

    // Build the full line pattern for one byte; bit 0 goes out first.
    function automatic frame_t build_frame(input logic [7:0] b);
        return {2'b11, ^b, b, 1'b0};
    endfunction

endpackage

// File: rtl/sc_tick_div.sv
module sc_tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] last_cnt;

    always_comb begin
        st_d     = st_q;
        eff_div  = (divisor == '0) ? DIV_W'(1) : divisor;
        last_cnt = eff_div - DIV_W'(1);
        tick     = run && (st_q.cnt >= last_cnt);
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sc_byte_fifo.sv
module sc_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        push_ok, pop_ok;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        count   = st_q.cnt;
        rdata   = st_q.mem[st_q.rp];
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = wrap_inc(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = wrap_inc(st_q.rp);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sc_frame_seq.sv
module sc_frame_seq
    import sc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic       src_empty,
    input  logic [7:0] src_data,
    output logic       pop,
    output logic       busy,
    output logic       line
);

    seq_state_t st_d, st_q;
    logic       can_launch;

    always_comb begin
        st_d       = st_q;
        pop        = 1'b0;
        can_launch = enable && !src_empty;
        if (!st_q.busy) begin
            if (can_launch) begin
                pop        = 1'b1;
                st_d.busy  = 1'b1;
                st_d.sub   = '0;
                st_d.slot  = '0;
                st_d.frame = build_frame(src_data);
            end
        end else if (tick) begin
            if (st_q.sub == LAST_SUB) begin
                st_d.sub = '0;
                if (st_q.slot == LAST_SLOT) begin
                    if (can_launch) begin
                        pop        = 1'b1;
                        st_d.slot  = '0;
                        st_d.frame = build_frame(src_data);
                    end else begin
                        st_d.busy  = 1'b0;
                        st_d.slot  = '0;
                        st_d.frame = '1;
                    end
                end else begin
                    st_d.slot  = st_q.slot + slot_idx_t'(1);
                    st_d.frame = {1'b1, st_q.frame[FRAME_LEN-1:1]};
                end
            end else begin
                st_d.sub = st_q.sub + tick_idx_t'(1);
            end
        end
        busy = st_q.busy;
        line = st_q.frame[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy  <= 1'b0;
            st_q.sub   <= '0;
            st_q.slot  <= '0;
            st_q.frame <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
    parameter int DIV_W = 16,
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             line_out,
    output logic             idle
);

    logic          tick_w;
    logic          busy_w;
    logic          pop_w;
    logic          full_w;
    logic          empty_w;
    logic [7:0]    head_w;
    logic [CW-1:0] count_w;

    sc_tick_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (busy_w),
        .divisor(divisor),
        .tick   (tick_w)
    );

    sc_byte_fifo #(
        .WIDTH(8),
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (in_valid),
        .wdata(in_data),
        .pop  (pop_w),
        .rdata(head_w),
        .full (full_w),
        .empty(empty_w),
        .count(count_w)
    );

    sc_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .tick     (tick_w),
        .src_empty(empty_w),
        .src_data (head_w),
        .pop      (pop_w),
        .busy     (busy_w),
        .line     (line_out)
    );

    assign in_ready = !full_w;
    assign idle     = empty_w && !busy_w;

endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          enable,
    input logic          line_out,
    input logic          idle,
    input logic          busy,
    input logic          tick,
    input logic          pop,
    input logic [CW-1:0] count
);

    // R6: nothing in flight means a high line
    p_idle_line_high_r6: assert property (@(posedge clk) disable iff (rst)
        idle |-> line_out);

    // R10: a character is only launched while enabled
    p_launch_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> enable);

    // R7: occupancy bound
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R7: never take a byte from an empty queue
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    // R2: the line only moves on a tick while a character is in flight
    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(line_out));

    // R9: a start edge is never seen while idle is reported
    p_fall_not_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(line_out) |-> !idle);

endmodule

bind sc_char_tx sc_char_tx_chk #(
    .DEPTH(DEPTH),
    .CW   (CW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .line_out(line_out),
    .idle    (idle),
    .busy    (busy_w),
    .tick    (tick_w),
    .pop     (pop_w),
    .count   (count_w)
);

// File: tb/sim_sc_char_tx.sv
module sim_sc_char_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic [15:0] cur_div = 16'd1;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, line_out, idle;

    int          n_checks = 0;
    int          n_fail = 0;
    int          gap = 0;
    int          chars_done = 0;
    logic [7:0]  exp_q[$];
    int          gaps_q[$];

    always #4 clk = ~clk;

    sc_char_tx u0 (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .divisor (cur_div),
        .in_data (in_data),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .line_out(line_out),
        .idle    (idle)
    );

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    function automatic logic frame_bit(input logic [7:0] b, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return b[i-1];
        if (i == 9) return ^b;
        return 1'b1;
    endfunction

    function automatic string slot_tag(input int i);
        if (i <= 8) return "R3";
        if (i == 9) return "R4";
        return "R5";
    endfunction

    function automatic int etu_cycles(input logic [15:0] d);
        return 5 * ((d == 16'd0) ? 1 : int'(d));
    endfunction

    // Line monitor: every cycle of every bit is compared to the model (R2..R5).
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                gap = 0;
                continue;
            end
            if (line_out === 1'b0) begin
                automatic int         etu = etu_cycles(cur_div);
                automatic logic [7:0] b = 8'h00;
                gaps_q.push_back(gap);
                gap = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected character", 1, 0);
                end else begin
                    b = exp_q.pop_front();
                end
                for (int s = 0; s < 12; s++) begin
                    automatic logic ok = 1'b1;
                    automatic logic seen = frame_bit(b, s);
                    for (int c = 0; c < etu; c++) begin
                        if (s != 0 || c != 0) @(negedge clk);
                        if (line_out !== frame_bit(b, s) && ok) begin
                            ok = 1'b0;
                            seen = line_out;
                        end
                    end
                    check(ok, slot_tag(s), int'(seen), int'(frame_bit(b, s)));
                end
                chars_done++;
            end else begin
                gap++;
            end
        end
    end

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        @(posedge clk);
        exp_q.push_back(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(idle && exp_q.size() == 0)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 190000, 0);
        finish_run();
    end

    initial begin
        automatic int unsigned seed_dummy = $urandom(32'h0C0D_E7A1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(line_out === 1'b1, "R1 line", int'(line_out), 1);
        check(idle === 1'b1, "R1 idle", int'(idle), 1);
        check(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R11 launch latency, R9 idle drops once a byte is held
        cur_div = 16'd2;
        @(negedge clk);
        in_data  = 8'h3C;
        in_valid = 1'b1;
        @(posedge clk);
        exp_q.push_back(8'h3C);
        @(negedge clk);
        in_valid = 1'b0;
        check(line_out === 1'b1, "R11 before launch", int'(line_out), 1);
        check(idle === 1'b0, "R9 queued", int'(idle), 0);
        @(negedge clk);
        check(line_out === 1'b0, "R11 launch edge", int'(line_out), 0);
        repeat (20) @(negedge clk);
        check(idle === 1'b0, "R9 in flight", int'(idle), 0);
        wait_idle();
        check(idle === 1'b1 && line_out === 1'b1, "R6 after char", int'({idle, line_out}), 3);

        // R2 divisor zero behaves as one
        cur_div = 16'd0;
        push_byte(8'hA7);
        wait_idle();

        // R4 parity corners at divisor 1
        cur_div = 16'd1;
        push_byte(8'h00);
        push_byte(8'hFF);
        push_byte(8'h01);
        push_byte(8'h80);
        wait_idle();

        // R3/R4/R5 random bytes and divisors
        for (int batch = 0; batch < 6; batch++) begin
            cur_div = 16'($urandom_range(0, 4));
            for (int k = 0; k < 5; k++) begin
                push_byte(8'($urandom));
                if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 40)) @(negedge clk);
            end
            wait_idle();
        end

        // R7/R10 fill while disabled, extra byte dropped; R8 back-to-back
        cur_div = 16'd1;
        enable  = 1'b0;
        push_byte(8'h11);
        push_byte(8'h22);
        push_byte(8'h33);
        push_byte(8'h44);
        @(negedge clk);
        check(in_ready === 1'b0, "R7 full", int'(in_ready), 0);
        check(idle === 1'b0, "R9 full idle", int'(idle), 0);
        in_data  = 8'hA5;
        in_valid = 1'b1;
        begin
            automatic logic held = 1'b1;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (line_out !== 1'b1) held = 1'b0;
            end
            check(held, "R10 no launch while disabled", int'(held), 1);
        end
        in_valid = 1'b0;
        gaps_q.delete();
        @(negedge clk);
        enable = 1'b1;
        wait_idle();
        check(gaps_q.size() == 4, "R7 char count", gaps_q.size(), 4);
        if (gaps_q.size() == 4) begin
            for (int g = 1; g < 4; g++) begin
                check(gaps_q[g] == 0, "R8 gap", gaps_q[g], 0);
            end
        end

        // R10 disable mid-character: current one finishes, next waits
        cur_div = 16'd3;
        push_byte(8'h5A);
        push_byte(8'hC3);
        @(negedge clk);
        while (line_out) @(negedge clk);
        enable = 1'b0;
        begin
            automatic int base = chars_done;
            while (chars_done == base) @(negedge clk);
        end
        begin
            automatic logic held = 1'b1;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (line_out !== 1'b1) held = 1'b0;
            end
            check(held, "R10 held after finish", int'(held), 1);
        end
        check(exp_q.size() == 1, "R10 first completed", exp_q.size(), 1);
        check(idle === 1'b0, "R9 byte pending", int'(idle), 0);
        enable = 1'b1;
        wait_idle();
        check(idle === 1'b1, "R9 drained", int'(idle), 1);
        check(in_ready === 1'b1, "R7 ready when empty", int'(in_ready), 1);

        if (seed_dummy == 32'hFFFF_FFFF) $display("seed");
        finish_run();
    end

endmodule